// File: doc/BRIEF.md
# Transceiver Boundary-Scan Data Register

This block is the 88-cell boundary data register for a 20-bit two-port bus transceiver under IEEE 1149.1-style test. The test access port controller drives its capture, shift and update strobes. The instruction decoder supplies a one-bit capture-source select. Each cell has a shift stage, clocked on the rising test clock edge, and an update latch, clocked on the falling edge. The update latches hold the values that drive the pins and the transceiver core while a test instruction is active.

Cells 87 down to 80 belong to the eight control inputs. The A and B data pins are bidirectional, so each of them has two cells: one observes the data coming in and one holds the data going out. Serial data enters at cell 87 and leaves from cell 0.

A capture either samples the pin side of the device or the core side, as the select chooses. The serial output changes on the falling edge. It is qualified by an enable that is high only while shifting, which models a high-impedance output at all other times.

Top module: `bsr_xcvr_scan`

## Requirements
- R1: On a synchronous reset (`rst` high at a clock edge), every shift stage and update latch clears to 0, except cells 87 and 86, which set to 1. `tdo_en` is 0 after reset.
- R2: At each rising edge with `shift_en` high and `cap_en` low, `tdi` enters cell 87 and every cell n takes the old value of cell n+1. Cell 0 is the serial output.
- R3: At each falling edge, `tdo` takes the value that cell 0 holds at that moment, and `tdo_en` takes the value of `shift_en`.
- R4: The update latches copy the shift stages only at a falling edge where `upd_en` is high. At every other time they hold, including during shifting.
- R5: A rising edge with `cap_en` high and `cap_sel` = 0 (pin side) loads the cells as follows:
  - cells 87..80 take `pin_ctrl[7:0]`;
  - cells 79..60 take `pin_a[19:0]`, and cells 59..40 also take `pin_a[19:0]`;
  - cells 39..20 take `pin_b[19:0]`, and cells 19..0 also take `pin_b[19:0]`.
  In each range, bit 19 lands in the highest cell. `cap_en` has priority over `shift_en`.
- R6: A rising edge with `cap_en` high and `cap_sel` = 1 (core side) loads the cells as follows:
  - the control cells and both input-cell groups (87..60 and 39..20) take their own update-latch values;
  - cells 59..40 take `core_a_out[19:0]`;
  - cells 19..0 take `core_b_out[19:0]`.
- R7: The update latches leave the block on five ports:
  - `drv_ctrl[7:0]` = cells 87..80;
  - `drv_a_in` = cells 79..60;
  - `drv_a_out` = cells 59..40;
  - `drv_b_in` = cells 39..20;
  - `drv_b_out` = cells 19..0.
  The most significant port bit maps to the highest cell.
- R8: A rising edge with neither `cap_en` nor `shift_en` high leaves every shift stage unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset (power-up or Test-Logic-Reset) |
| cap_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe, sampled on the falling edge |
| tdi | input | 1 | Serial data in |
| cap_sel | input | 1 | Capture source: 0 pin side, 1 core side |
| pin_ctrl | input | 8 | Control pin values; bit 7 is OE A-to-B, bit 6 is OE B-to-A |
| pin_a | input | 20 | A-side pin values |
| pin_b | input | 20 | B-side pin values |
| core_a_out | input | 20 | Core outputs toward the A pins |
| core_b_out | input | 20 | Core outputs toward the B pins |
| tdo | output | 1 | Serial data out |
| tdo_en | output | 1 | Serial output enable |
| drv_ctrl | output | 8 | Update latches of the control cells |
| drv_a_in | output | 20 | Update latches of the A input cells |
| drv_a_out | output | 20 | Update latches of the A output cells |
| drv_b_in | output | 20 | Update latches of the B input cells |
| drv_b_out | output | 20 | Update latches of the B output cells |

## Verification
The bench first shifts out the reset contents. A design that clears the two output-enable cells, or sets the wrong pair, shows a misplaced pair of ones in the last two bits that come out.

Pin and core captures use random pin values. They are followed by full 88-bit shifts, so a swapped A/B range, a reversed field, or inputs and outputs crossed within one pin all appear as mismatched serial bits.

The outputs are compared on every cycle, including long shift runs and idle cycles. An update latch that follows the shift stages, or updates on the wrong edge, makes the pin drive ripple and is caught. So is a serial output that is late by half a cycle or is enabled outside shifting.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    localparam int DATA_W = 20;
    localparam int CTRL_W = 8;
    localparam int N_OE   = 2;
    localparam int CELLS  = CTRL_W + 4 * DATA_W;

    // Lowest cell of each group; the order is fixed by the serial chain
    localparam int B_OUT_LO = 0;
    localparam int B_IN_LO  = DATA_W;
    localparam int A_OUT_LO = 2 * DATA_W;
    localparam int A_IN_LO  = 3 * DATA_W;
    localparam int CTRL_LO  = 4 * DATA_W;

    typedef enum logic {
        CAP_PIN  = 1'b0,
        CAP_CORE = 1'b1
    } cap_src_e;

    // First member is most significant, so the struct lines up with cells 87..0
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] a_in;
        logic [DATA_W-1:0] a_out;
        logic [DATA_W-1:0] b_in;
        logic [DATA_W-1:0] b_out;
    } cell_view_t;

    // Output-enable cells sit at the top of the chain and reset high
    function automatic logic [CELLS-1:0] reset_vector();
        logic [CELLS-1:0] v;
        v = '0;
        for (int i = 0; i < N_OE; i++) begin
            v[CELLS-1-i] = 1'b1;
        end
        return v;
    endfunction

    localparam logic [CELLS-1:0] RST_VEC = reset_vector();

endpackage

// File: rtl/bsr_scan_cell.sv
module bsr_scan_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic cap_en,
    input  logic shift_en,
    input  logic cap_d,
    input  logic shift_d,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else if (cap_en) begin
            q <= cap_d;
        end else if (shift_en) begin
            q <= shift_d;
        end
    end

endmodule

// File: rtl/bsr_update_bank.sv
module bsr_update_bank #(
    parameter int                 WIDTH   = 88,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Falling-edge latch bank: pin drive moves only on an update
    always_ff @(negedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else if (upd_en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/bsr_tdo_stage.sv
module bsr_tdo_stage (
    input  logic clk,
    input  logic rst,
    input  logic shift_en,
    input  logic last_cell,
    output logic tdo,
    output logic tdo_en
);

    always_ff @(negedge clk) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= last_cell;
            tdo_en <= shift_en;
        end
    end

endmodule

// File: rtl/bsr_xcvr_scan.sv
module bsr_xcvr_scan
    import bsr_pkg::*;
#(
    parameter int D_W = bsr_pkg::DATA_W,
    parameter int C_W = bsr_pkg::CTRL_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cap_en,
    input  logic           shift_en,
    input  logic           upd_en,
    input  logic           tdi,
    input  logic           cap_sel,
    input  logic [C_W-1:0] pin_ctrl,
    input  logic [D_W-1:0] pin_a,
    input  logic [D_W-1:0] pin_b,
    input  logic [D_W-1:0] core_a_out,
    input  logic [D_W-1:0] core_b_out,
    output logic           tdo,
    output logic           tdo_en,
    output logic [C_W-1:0] drv_ctrl,
    output logic [D_W-1:0] drv_a_in,
    output logic [D_W-1:0] drv_a_out,
    output logic [D_W-1:0] drv_b_in,
    output logic [D_W-1:0] drv_b_out
);

    localparam int N = C_W + 4 * D_W;

    logic [N-1:0] sr_q;
    logic [N-1:0] upd_q;
    logic [N-1:0] shift_src;
    logic [N-1:0] cap_vec;
    cell_view_t   pin_view;
    cell_view_t   core_view;
    cell_view_t   upd_view;
    cap_src_e     src;

    assign src      = cap_src_e'(cap_sel);
    assign upd_view = cell_view_t'(upd_q);

    // Pin side: a bidirectional pin is one wire seen by both of its cells
    always_comb begin
        pin_view.ctrl  = pin_ctrl;
        pin_view.a_in  = pin_a;
        pin_view.a_out = pin_a;
        pin_view.b_in  = pin_b;
        pin_view.b_out = pin_b;
    end

    // Core side: input cells read back what they drive, output cells see the core
    always_comb begin
        core_view.ctrl  = upd_view.ctrl;
        core_view.a_in  = upd_view.a_in;
        core_view.a_out = core_a_out;
        core_view.b_in  = upd_view.b_in;
        core_view.b_out = core_b_out;
    end

    always_comb begin
        unique case (src)
            CAP_PIN:  cap_vec = N'(pin_view);
            CAP_CORE: cap_vec = N'(core_view);
            default:  cap_vec = N'(pin_view);
        endcase
    end

    assign shift_src = {tdi, sr_q[N-1:1]};

    for (genvar i = 0; i < N; i++) begin : g_cell
        bsr_scan_cell #(
            .RST_VAL (RST_VEC[i])
        ) u_cell (
            .clk      (clk),
            .rst      (rst),
            .cap_en   (cap_en),
            .shift_en (shift_en),
            .cap_d    (cap_vec[i]),
            .shift_d  (shift_src[i]),
            .q        (sr_q[i])
        );
    end

    bsr_update_bank #(
        .WIDTH   (N),
        .RST_VAL (RST_VEC)
    ) u_upd (
        .clk    (clk),
        .rst    (rst),
        .upd_en (upd_en),
        .d      (sr_q),
        .q      (upd_q)
    );

    bsr_tdo_stage u_tdo (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (shift_en),
        .last_cell (sr_q[0]),
        .tdo       (tdo),
        .tdo_en    (tdo_en)
    );

    assign drv_ctrl  = upd_view.ctrl;
    assign drv_a_in  = upd_view.a_in;
    assign drv_a_out = upd_view.a_out;
    assign drv_b_in  = upd_view.b_in;
    assign drv_b_out = upd_view.b_out;

endmodule

// File: rtl/bsr_xcvr_scan_chk.sv
module bsr_xcvr_scan_chk
    import bsr_pkg::*;
#(
    parameter int N = bsr_pkg::CELLS
) (
    input logic         clk,
    input logic         rst,
    input logic         cap_en,
    input logic         shift_en,
    input logic         upd_en,
    input logic         tdi,
    input logic         tdo,
    input logic         tdo_en,
    input logic [N-1:0] sr_q,
    input logic [N-1:0] upd_q
);

    AST_RST_SHIFT_VAL: assert property (@(posedge clk)
        rst |=> sr_q == RST_VEC); // R1

    AST_RST_UPD_VAL: assert property (@(negedge clk)
        rst |=> (upd_q == RST_VEC) && !tdo_en); // R1

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
        shift_en && !cap_en |=>
            (sr_q[N-2:0] == $past(sr_q[N-1:1])) && (sr_q[N-1] == $past(tdi))); // R2

    AST_TDO_FOLLOWS: assert property (@(negedge clk) disable iff (rst)
        1'b1 |=> tdo == $past(sr_q[0])); // R3

    AST_TDO_EN_ON: assert property (@(negedge clk) disable iff (rst)
        shift_en |=> tdo_en); // R3

    AST_TDO_EN_OFF: assert property (@(negedge clk) disable iff (rst)
        !shift_en |=> !tdo_en); // R3

    AST_UPD_HOLD: assert property (@(negedge clk) disable iff (rst)
        !upd_en |=> $stable(upd_q)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap_en && !shift_en |=> $stable(sr_q)); // R8

endmodule

bind bsr_xcvr_scan bsr_xcvr_scan_chk #(
    .N (bsr_pkg::CELLS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (cap_en),
    .shift_en (shift_en),
    .upd_en   (upd_en),
    .tdi      (tdi),
    .tdo      (tdo),
    .tdo_en   (tdo_en),
    .sr_q     (sr_q),
    .upd_q    (upd_q)
);

// File: tb/bsr_xcvr_scan_test.sv
`timescale 1ns/100ps
module bsr_xcvr_scan_test;

    localparam int NC = 88;
    localparam logic [NC-1:0] RSTV = {2'b11, 86'b0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_en = 1'b0, shift_en = 1'b0, upd_en = 1'b0, tdi = 1'b0, cap_sel = 1'b0;
    logic [7:0]  pin_ctrl = '0;
    logic [19:0] pin_a = '0, pin_b = '0, core_a_out = '0, core_b_out = '0;
    logic        tdo, tdo_en;
    logic [7:0]  drv_ctrl;
    logic [19:0] drv_a_in, drv_a_out, drv_b_in, drv_b_out;

    int n_vec = 0;
    int n_bad = 0;
    logic [NC-1:0] exp_sr, exp_upd;

    always #2 clk = ~clk;

    bsr_xcvr_scan uut (
        .clk(clk), .rst(rst), .cap_en(cap_en), .shift_en(shift_en), .upd_en(upd_en),
        .tdi(tdi), .cap_sel(cap_sel), .pin_ctrl(pin_ctrl), .pin_a(pin_a), .pin_b(pin_b),
        .core_a_out(core_a_out), .core_b_out(core_b_out), .tdo(tdo), .tdo_en(tdo_en),
        .drv_ctrl(drv_ctrl), .drv_a_in(drv_a_in), .drv_a_out(drv_a_out),
        .drv_b_in(drv_b_in), .drv_b_out(drv_b_out)
    );

    function automatic logic [NC-1:0] pin_side();
        return {pin_ctrl, pin_a, pin_a, pin_b, pin_b};
    endfunction

    function automatic logic [NC-1:0] core_side(input logic [NC-1:0] u);
        return {u[87:80], u[79:60], core_a_out, u[39:20], core_b_out};
    endfunction

    task automatic check(input bit ok, input string req, input logic [NC-1:0] act,
                         input logic [NC-1:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NC-1:0] drv_all();
        return {drv_ctrl, drv_a_in, drv_a_out, drv_b_in, drv_b_out};
    endfunction

    // One controller cycle: drive after the rising edge, check after the falling edge
    task automatic cyc(input logic c, input logic s, input logic u, input logic d,
                       input logic sel);
        logic e_tdo;
        @(posedge clk);
        #1;
        cap_en = c; shift_en = s; upd_en = u; tdi = d; cap_sel = sel;
        @(negedge clk);
        #1;
        if (u) exp_upd = exp_sr;
        e_tdo = exp_sr[0];
        check(drv_all() === exp_upd, u ? "R4/R7 update" : "R4 hold", drv_all(), exp_upd);
        check(tdo_en === s, "R3 tdo_en", NC'(tdo_en), NC'(s));
        if (s) check(tdo === e_tdo, "R2/R3 tdo bit", NC'(tdo), NC'(e_tdo));
        if (c) exp_sr = sel ? core_side(exp_upd) : pin_side();
        else if (s) exp_sr = {d, exp_sr[NC-1:1]};
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1; cap_en = 0; shift_en = 0; upd_en = 0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        exp_sr = RSTV;
        exp_upd = RSTV;
        check(drv_all() === RSTV, "R1 reset latches", drv_all(), RSTV);
        check(tdo_en === 1'b0, "R1 tdo_en reset", NC'(tdo_en), '0);
    endtask

    task automatic randomize_pins();
        pin_ctrl = 8'($urandom);
        pin_a = 20'($urandom); pin_b = 20'($urandom);
        core_a_out = 20'($urandom); core_b_out = 20'($urandom);
    endtask

    initial begin : watchdog
        #400000;
        n_vec++; n_bad++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5eed_0017));
        do_reset();
        // R1/R2: unload reset contents, the two set cells emerge last
        for (int i = 0; i < NC; i++) cyc(0, 1, 0, 1'b0, 0);
        // R8: idle cycles keep the chain
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1'b0, 0);
        // R2/R4/R7: walking pattern in, then update
        for (int i = 0; i < NC; i++) cyc(0, 1, 0, logic'(i % 3 == 0), 0);
        cyc(0, 0, 1, 1'b0, 0);
        for (int i = 0; i < NC; i++) cyc(0, 1, 0, 1'b1, 0);
        cyc(0, 0, 1, 1'b0, 0);
        // R5: pin-side capture of random pins, full unload
        randomize_pins();
        cyc(1, 0, 0, 1'b0, 0);
        for (int i = 0; i < NC; i++) cyc(0, 1, 0, 1'($urandom), 0);
        cyc(0, 0, 1, 1'b0, 0);
        // R6: core-side capture, full unload
        randomize_pins();
        cyc(1, 0, 0, 1'b0, 1);
        for (int i = 0; i < NC; i++) cyc(0, 1, 0, 1'($urandom), 0);
        // R5: capture wins over shift in the same cycle
        randomize_pins();
        cyc(1, 1, 0, 1'b1, 0);
        for (int i = 0; i < NC; i++) cyc(0, 1, 0, 1'b0, 0);
        // R1: reset in mid-pattern
        for (int i = 0; i < 30; i++) cyc(0, 1, 0, 1'b1, 0);
        cyc(0, 0, 1, 1'b0, 0);
        do_reset();
        for (int i = 0; i < NC; i++) cyc(0, 1, 0, 1'b0, 0);
        // Random mix of strobes
        for (int k = 0; k < 3000; k++) begin
            int op;
            op = int'($urandom % 16);
            if (op < 2) begin randomize_pins(); cyc(1, 0, 0, 1'b0, 0); end
            else if (op == 2) begin randomize_pins(); cyc(1, 0, 0, 1'b0, 1); end
            else if (op < 5) cyc(0, 0, 1, 1'b0, 0);
            else if (op == 5) cyc(0, 0, 0, 1'b0, 0);
            else cyc(0, 1, 0, 1'($urandom), 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule